// File: doc/BRIEF.md
# Dual-Width Word-Assembling FIFO Port

This block is an eight-entry, 32-bit synchronous FIFO. Its external side is reached either one whole word per strobe or one 16-bit half per strobe. A width input picks between the two. In half-width mode, a write-side position pointer collects two consecutive halves into one word before the word enters the storage. A read-side position pointer presents the two halves of the head word one after the other, and pops the word only after its second half.

A programmable advance setting selects which physical half completes a word, and so which half the FIFO pointer moves on. With the setting at "upper", each word is transferred lower half first and upper half second. With the setting at "lower", the order is upper half first and lower half second. Write and read strobes are gated inside the block by full and empty, so a refused access never moves a position pointer. The halves therefore cannot fall out of step with the words.

The block reports full, empty, "at least four free entries" and "at least four filled entries". A synchronous flag-clear input returns the FIFO to its empty, word-aligned state.

Top module: `dwf_port`

## Requirements
- R1: After reset the port is empty (empty=1, full=0, room4=1, fill4=0), and both position pointers stand at the first half of a word.
- R2: With wide_mode=1, every accepted write stores wr_data as one word, and every accepted read pops one word. rd_data shows the head word combinationally, in write order.
- R3: With wide_mode=0, only wr_data[15:0] is used. The first accepted half is held, and the second accepted half completes the word and pushes it.
- R4: adv_on_upper=1 places the first half in bits [15:0] and the second half in bits [31:16]. adv_on_upper=0 places the first half in bits [31:16] and the second half in bits [15:0].
- R5: With wide_mode=0, rd_data[15:0] shows the head word's half at the current read position (mapped as in R4), with rd_data[31:16]=0. An accepted read moves to the second position, and the next accepted read pops the word.
- R6: A write while full is discarded and leaves the write position pointer unchanged.
- R7: A read while empty pops nothing and leaves the read position pointer unchanged.
- R8: full=1 exactly at 8 stored words, empty=1 exactly at 0, room4=1 when at most 4 words are stored, and fill4=1 when at least 4 words are stored.
- R9: A same-cycle push and pop, with the FIFO neither full nor empty, leaves the stored word count unchanged.
- R10: flag_clr=1 empties the FIFO and returns both position pointers to the first half on the next edge, overriding any strobe in that cycle.
- R11: wide_mode and adv_on_upper change only while both position pointers stand at the first half of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_clr | input | 1 | Synchronous FIFO clear |
| wide_mode | input | 1 | 1: 32-bit access, 0: 16-bit access |
| adv_on_upper | input | 1 | 1: upper half completes a word, 0: lower half does |
| wr_en | input | 1 | Write strobe (synchronous enable) |
| wr_data | input | 32 | Write data; bits [15:0] only in 16-bit mode |
| rd_en | input | 1 | Read strobe (synchronous enable) |
| rd_data | output | 32 | Head word, or selected half zero-extended |
| full | output | 1 | Eight words stored |
| empty | output | 1 | No word stored |
| room4 | output | 1 | At least four free entries |
| fill4 | output | 1 | At least four filled entries |

## Verification
The assertions watch, on every cycle, that pointers hold when the FIFO is full or empty and that a refused strobe never moves a position pointer. They also check that clearing empties the FIFO, that a push with a pop keeps the count, and that the width or order settings change only at a word boundary. Only the bench scenarios can show the word layout for each advance setting, the order of halves seen on rd_data, and that data written after a refused or cleared half-access still lands in the right position.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

    localparam int WORD_W      = 32;
    localparam int HALF_W      = WORD_W / 2;
    localparam int FIFO_DEPTH  = 8;
    localparam int FLAG_THRESH = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    // position of a half inside a word transfer sequence
    typedef enum logic {
        POS_FIRST  = 1'b0,
        POS_SECOND = 1'b1
    } hpos_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic room4;
        logic fill4;
    } flags_t;

    // true when the given position maps to the upper physical half
    function automatic logic pos_is_upper(hpos_t p, logic adv_upper);
        return (p == POS_SECOND) == adv_upper;
    endfunction

    function automatic word_t merge_halves(half_t first_h, half_t second_h, logic adv_upper);
        return adv_upper ? {second_h, first_h} : {first_h, second_h};
    endfunction

    function automatic half_t pick_half(word_t w, hpos_t p, logic adv_upper);
        return pos_is_upper(p, adv_upper) ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/dwf_store.sv
module dwf_store
    import dwf_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int THRESH = FLAG_THRESH
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   push,
    input  word_t  push_word,
    input  logic   pop,
    output word_t  head,
    output flags_t flags
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr, rptr, count;
    word_t         mem [DEPTH];

    assign count = wptr - rptr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + PW'(1);
            if (pop)  rptr <= rptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr && !rst) mem[wptr[AW-1:0]] <= push_word;
    end

    assign head        = mem[rptr[AW-1:0]];
    assign flags.full  = (count == PW'(DEPTH));
    assign flags.empty = (count == '0);
    assign flags.room4 = ((PW'(DEPTH) - count) >= PW'(THRESH));
    assign flags.fill4 = (count >= PW'(THRESH));

    // R6: no slot is written while full
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (flags.full && !clr) |=> (wptr == $past(wptr)));

    // R7: the read pointer never moves while empty
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && !clr) |=> (rptr == $past(rptr)));

    // R10: clearing leaves the store empty
    p_clr_empty_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags.empty && !flags.full));

    // R9: push with pop keeps occupancy
    p_pushpop_r9: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/dwf_wr_side.sv
module dwf_wr_side
    import dwf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  wide,
    input  logic  adv_upper,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  full,
    output logic  push,
    output word_t push_word,
    output hpos_t pos
);
    logic  accept;
    half_t hold;
    half_t in_half;

    assign in_half = wr_data[HALF_W-1:0];
    assign accept  = wr_en && !full;
    assign push    = accept && (wide || pos == POS_SECOND);
    assign push_word = wide ? wr_data : merge_halves(hold, in_half, adv_upper);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos <= POS_FIRST;
        end else if (accept && !wide) begin
            pos <= (pos == POS_FIRST) ? POS_SECOND : POS_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (accept && !wide && pos == POS_FIRST) begin
            hold <= in_half;
        end
    end

    // R6: a refused write does not move the write position
    p_wpos_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !clr) |=> (pos == $past(pos)));

endmodule

// File: rtl/dwf_rd_side.sv
module dwf_rd_side
    import dwf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  wide,
    input  logic  adv_upper,
    input  logic  rd_en,
    input  logic  empty,
    input  word_t head,
    output logic  pop,
    output word_t rd_data,
    output hpos_t pos
);
    logic accept;

    assign accept  = rd_en && !empty;
    assign pop     = accept && (wide || pos == POS_SECOND);
    assign rd_data = wide ? head : {{HALF_W{1'b0}}, pick_half(head, pos, adv_upper)};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos <= POS_FIRST;
        end else if (accept && !wide) begin
            pos <= (pos == POS_FIRST) ? POS_SECOND : POS_FIRST;
        end
    end

    // R7: a refused read does not move the read position
    p_rpos_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !clr) |=> (pos == $past(pos)));

endmodule

// File: rtl/dwf_port.sv
module dwf_port
    import dwf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flag_clr,
    input  logic                wide_mode,
    input  logic                adv_on_upper,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    output logic                full,
    output logic                empty,
    output logic                room4,
    output logic                fill4
);
    logic   push, pop;
    word_t  push_word, head;
    flags_t flags;
    hpos_t  wpos, rpos;

    dwf_wr_side u_wr (
        .clk       (clk),
        .rst       (rst),
        .clr       (flag_clr),
        .wide      (wide_mode),
        .adv_upper (adv_on_upper),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .full      (flags.full),
        .push      (push),
        .push_word (push_word),
        .pos       (wpos)
    );

    dwf_rd_side u_rd (
        .clk       (clk),
        .rst       (rst),
        .clr       (flag_clr),
        .wide      (wide_mode),
        .adv_upper (adv_on_upper),
        .rd_en     (rd_en),
        .empty     (flags.empty),
        .head      (head),
        .pop       (pop),
        .rd_data   (rd_data),
        .pos       (rpos)
    );

    dwf_store #(
        .DEPTH  (FIFO_DEPTH),
        .THRESH (FLAG_THRESH)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (flag_clr),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head      (head),
        .flags     (flags)
    );

    assign full  = flags.full;
    assign empty = flags.empty;
    assign room4 = flags.room4;
    assign fill4 = flags.fill4;

    // R11: width changes only at a word boundary on both sides
    p_mode_change_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(wide_mode) |-> (wpos == POS_FIRST && rpos == POS_FIRST));

    // R11: order setting changes only at a word boundary on both sides
    p_adv_change_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(adv_on_upper) |-> (wpos == POS_FIRST && rpos == POS_FIRST));

endmodule

// File: tb/dwf_port_tb.sv
`timescale 1ns/1ps
module dwf_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flag_clr = 1'b0;
    logic        wide_mode = 1'b1;
    logic        adv_on_upper = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        full, empty, room4, fill4;

    always #2.5 clk = ~clk;

    dwf_port u_dut (
        .clk          (clk),
        .rst          (rst),
        .flag_clr     (flag_clr),
        .wide_mode    (wide_mode),
        .adv_on_upper (adv_on_upper),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .full         (full),
        .empty        (empty),
        .room4        (room4),
        .fill4        (fill4)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    string       tag    = "R2";

    // scoreboard model: words in FIFO order, plus position state
    logic [31:0] q[$];
    int          mcount = 0;
    bit          mwsel  = 1'b0;
    bit          mrsel  = 1'b0;
    logic [15:0] mhold  = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares outputs, then advances the model for the coming edge
    always @(negedge clk) begin : monitor
        logic [31:0] exp_w;
        logic [3:0]  fexp, fact;
        bit          wacc, racc, upper;
        if (rst) begin
            q.delete(); mcount = 0; mwsel = 0; mrsel = 0;
        end else begin
            // R8 flags against the model count (R1 right after reset)
            fexp = {mcount == 8, mcount == 0, (8 - mcount) >= 4, mcount >= 4};
            fact = {full, empty, room4, fill4};
            chk(fact === fexp, "R8", {28'd0, fact}, {28'd0, fexp});
            if (flag_clr) begin
                q.delete(); mcount = 0; mwsel = 0; mrsel = 0;
            end else begin
                wacc = wr_en && (mcount < 8);
                racc = rd_en && (mcount > 0);
                if (racc) begin
                    if (wide_mode) exp_w = q[0];
                    else begin
                        upper = (mrsel == 1'b1) == adv_on_upper;
                        exp_w = {16'd0, upper ? q[0][31:16] : q[0][15:0]};
                    end
                    chk(rd_data === exp_w, tag, rd_data, exp_w);
                    if (wide_mode || mrsel) begin
                        void'(q.pop_front());
                        mcount--;
                    end
                    if (!wide_mode) mrsel = !mrsel;
                end
                if (wacc) begin
                    if (wide_mode) begin
                        q.push_back(wr_data); mcount++;
                    end else if (!mwsel) begin
                        mhold = wr_data[15:0];
                        mwsel = 1'b1;
                    end else begin
                        q.push_back(adv_on_upper ? {wr_data[15:0], mhold} : {mhold, wr_data[15:0]});
                        mcount++;
                        mwsel = 1'b0;
                    end
                end
            end
        end
    end

    task automatic cyc(input bit w, input logic [31:0] d, input bit r, input bit c);
        @(posedge clk); #1;
        wr_en = w; wr_data = d; rd_en = r; flag_clr = c;
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0);
    endtask

    task automatic set_mode(input bit w, input bit a);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; flag_clr = 0;
        wide_mode = w; adv_on_upper = a;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R1: reset state
        chk(empty && !full && room4 && !fill4, "R1", {28'd0, full, empty, room4, fill4}, 32'h6);

        // R2: whole-word writes and reads, interleaved
        tag = "R2";
        for (int i = 0; i < 5; i++) cyc(1, 32'hA000_0000 + i, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0);
        cyc(1, 32'h5555_AAAA, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0);
        idle();

        // R8 fill to full, R6 writes while full discarded
        tag = "R6";
        for (int i = 0; i < 8; i++) cyc(1, 32'hF0F0_0000 + i, 0, 0);
        idle(); #1;
        chk(full && fill4 && !room4, "R8", {28'd0, full, empty, room4, fill4}, 32'h9);
        cyc(1, 32'hDEAD_BEEF, 0, 0);
        cyc(1, 32'hDEAD_BEEF, 0, 0);
        for (int i = 0; i < 8; i++) cyc(0, '0, 1, 0);
        idle(); #1;
        chk(empty, "R6", {31'd0, empty}, 32'h1);

        // R7: reads while empty, then normal traffic
        tag = "R7";
        cyc(0, '0, 1, 0);
        cyc(0, '0, 1, 0);
        cyc(1, 32'h0BAD_F00D, 0, 0);
        cyc(0, '0, 1, 0);
        idle();

        // R3 R4 R5: half-width transfers, lower half first
        set_mode(0, 1);
        tag = "R3";
        for (int i = 0; i < 8; i++) cyc(1, 32'hFFFF_1100 + i, 0, 0);
        tag = "R5";
        for (int i = 0; i < 8; i++) cyc(0, '0, 1, 0);
        idle();

        // R4: layout with lower-first order, seen as a whole word
        tag = "R4";
        cyc(1, 32'h0000_AAAA, 0, 0);
        cyc(1, 32'h0000_BBBB, 0, 0);
        set_mode(1, 1); #1;
        chk(rd_data === 32'hBBBB_AAAA, "R4", rd_data, 32'hBBBB_AAAA);
        cyc(0, '0, 1, 0);
        // R4: upper-first order
        set_mode(0, 0);
        cyc(1, 32'h0000_CCCC, 0, 0);
        cyc(1, 32'h0000_DDDD, 0, 0);
        set_mode(1, 0); #1;
        chk(rd_data === 32'hCCCC_DDDD, "R4", rd_data, 32'hCCCC_DDDD);
        cyc(0, '0, 1, 0);

        // R5: whole word read as halves in both orders
        cyc(1, 32'h1234_5678, 0, 0);
        cyc(1, 32'h9ABC_DEF0, 0, 0);
        set_mode(0, 0); #1;
        tag = "R5";
        chk(rd_data === 32'h0000_1234, "R5", rd_data, 32'h0000_1234);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 1, 0);
        set_mode(0, 1); #1;
        chk(rd_data === 32'h0000_DEF0, "R5", rd_data, 32'h0000_DEF0);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 1, 0);
        idle();

        // R6: half write while full keeps alignment
        tag = "R6";
        for (int i = 0; i < 16; i++) cyc(1, 32'h0000_2200 + i, 0, 0);
        cyc(1, 32'h0000_EEEE, 0, 0);
        for (int i = 0; i < 16; i++) cyc(0, '0, 1, 0);
        cyc(1, 32'h0000_3131, 0, 0);
        cyc(1, 32'h0000_4242, 0, 0);
        set_mode(1, 1); #1;
        chk(rd_data === 32'h4242_3131, "R6", rd_data, 32'h4242_3131);
        cyc(0, '0, 1, 0);

        // R7: half read while empty keeps alignment
        set_mode(0, 1);
        tag = "R7";
        cyc(0, '0, 1, 0);
        cyc(0, '0, 1, 0);
        cyc(1, 32'h0000_5151, 0, 0);
        cyc(1, 32'h0000_6262, 0, 0);
        idle(); #1;
        chk(rd_data === 32'h0000_5151, "R7", rd_data, 32'h0000_5151);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 1, 0);
        idle();

        // R9: simultaneous push and pop keeps count
        set_mode(1, 1);
        tag = "R9";
        for (int i = 0; i < 3; i++) cyc(1, 32'h9900_0000 + i, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 32'h9911_0000 + i, 1, 0);
        idle(); #1;
        chk(room4 && !fill4 && !empty, "R9", {28'd0, full, empty, room4, fill4}, 32'h2);
        for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0);
        idle();

        // R10: clear overrides strobes
        tag = "R10";
        for (int i = 0; i < 5; i++) cyc(1, 32'hC1C1_0000 + i, 0, 0);
        cyc(1, 32'hFFFF_FFFF, 1, 1);
        idle(); #1;
        chk(empty && !full, "R10", {31'd0, empty}, 32'h1);
        // R10: clear mid-word realigns the half position
        set_mode(0, 1);
        cyc(1, 32'h0000_7777, 0, 0);
        cyc(0, '0, 0, 1);
        cyc(1, 32'h0000_8181, 0, 0);
        cyc(1, 32'h0000_9292, 0, 0);
        set_mode(1, 1); #1;
        chk(rd_data === 32'h9292_8181, "R10", rd_data, 32'h9292_8181);
        cyc(0, '0, 1, 0);
        idle();
        idle();

        chk(q.size() == 0, "R2", q.size(), 32'h0);
        finish_run();
    end

endmodule